// File: doc/BRIEF.md
# Dual-Mode Parallel Host Bus Slave

This block lets a host processor reach a peripheral's register file over a 16-bit parallel bus. A strap input picks one of two handshake styles. In acknowledge mode the host qualifies each cycle with an active-low data strobe and a read/write direction line, and the slave answers with an active-low acknowledge. In split-strobe mode the host uses separate active-low read and write strobes, and writes take effect when the write strobe rises.

Every incoming control pin passes through a two-stage synchroniser. Edges are then detected on the internal clock. The address is split into an axis index in the upper two bits and a word offset in the lower bits. The slave turns each host cycle into at most one single-cycle request on a simple internal read/write port. Axes at or above the configured count do not exist: they read back as zero and never produce a request. The data bus is modelled as an input, an output and an output enable.

Top module: `hbs_host_slave`

## Requirements
- R1: While reset is held and in the first cycles after it, `ack_n` is 1 and `hd_oe`, `rf_rd_en` and `rf_wr_en` are 0.
- R2: In acknowledge mode (`mode_sel`=0) with `rnw`=1, a falling `ds_n` while `cs_n`=0 gives exactly one `rf_rd_en` pulse on the third rising clock edge after the pin changes. From the fourth edge on, `hd_out` holds the register value and `hd_oe`=1 until the strobe is released.
- R3: In acknowledge mode, `ack_n` goes low on the fourth rising edge after `ds_n` falls, which is two clocks after the synchronised strobe is seen low. It returns high on the second edge after `ds_n` rises.
- R4: In acknowledge mode with `rnw`=0, a falling `ds_n` gives exactly one `rf_wr_en` pulse on the third edge, carrying the address and `hd_in` of that moment. `hd_oe` stays 0 throughout.
- R5: In split-strobe mode (`mode_sel`=1), a falling `rd_n` with `cs_n`=0 gives one `rf_rd_en` pulse on the third edge. `hd_out` is valid from the fourth edge, and `hd_oe`=1 until `rd_n` rises.
- R6: In split-strobe mode, no write request is made while `wr_n` is held low. One `rf_wr_en` pulse follows on the third edge after `wr_n` rises, carrying the address and data that were present while the strobe was low.
- R7: In split-strobe mode `ack_n` stays 1.
- R8: With `cs_n`=1, strobe activity makes no request, `hd_oe` stays 0 and `ack_n` stays 1.
- R9: An address whose axis field is not below `NUM_AXES` (default 3) reads as zero and issues neither `rf_rd_en` nor `rf_wr_en`.
- R10: `addr[6:5]` selects the axis (`rf_axis`) and `addr[4:0]` selects the word offset (`rf_offs`).
- R11: A strobe held active for many cycles gives only one request, and a read and a write request never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 1 | Handshake strap: 0 acknowledge mode, 1 split-strobe mode |
| cs_n | input | 1 | Active-low chip select |
| rnw | input | 1 | Direction in acknowledge mode: 1 read, 0 write |
| ds_n | input | 1 | Active-low data strobe, acknowledge mode |
| rd_n | input | 1 | Active-low read strobe, split-strobe mode |
| wr_n | input | 1 | Active-low write strobe, split-strobe mode |
| addr | input | 7 | Host word address: axis field and offset |
| hd_in | input | 16 | Data bus as seen from the host |
| hd_out | output | 16 | Read data driven toward the host |
| hd_oe | output | 1 | Data bus output enable |
| ack_n | output | 1 | Active-low acknowledge, acknowledge mode only |
| rf_rd_en | output | 1 | Single-cycle read request to the register file |
| rf_wr_en | output | 1 | Single-cycle write request to the register file |
| rf_axis | output | 2 | Axis index of the request |
| rf_offs | output | 5 | Word offset of the request |
| rf_wdata | output | 16 | Write data of the request |
| rf_rdata | input | 16 | Register file read data, valid while `rf_rd_en` is high |

## Verification
Every result is due a fixed number of rising edges after the bench moves a pin on a falling edge. The read or write request is due on the third edge, because two synchroniser stages and the request register lie on the way. Read data and the acknowledge are due on the fourth edge, and the release is due on the second edge after the strobe rises. Each check samples on the falling edge just after the due edge. Where the timing matters, the bench also checks the falling edge just before it, so a result that comes early or late by one cycle is reported.

// File: rtl/hbs_pkg.sv
`timescale 1ns/1ps
package hbs_pkg;

    localparam int AXIS_W   = 2;
    localparam int MAX_AXES = 4;
    localparam int DATA_W   = 16;

    typedef enum logic {
        BUS_ACK   = 1'b0,
        BUS_SPLIT = 1'b1
    } bus_mode_e;

    // Bundle of host control pins, carried through the synchroniser.
    typedef struct packed {
        logic cs_n;
        logic ds_n;
        logic rd_n;
        logic wr_n;
        logic rnw;
    } pins_t;

    localparam pins_t PINS_IDLE = '{cs_n: 1'b1, ds_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1, rnw: 1'b1};

    typedef struct packed {
        logic              hit;
        logic [AXIS_W-1:0] axis;
    } axis_sel_t;

    function automatic logic axis_in_range(input logic [AXIS_W-1:0] axis, input int lim);
        return int'(axis) < lim;
    endfunction

endpackage

// File: rtl/hbs_sync.sv
`timescale 1ns/1ps
module hbs_sync #(
    parameter int                 WIDTH   = 5,
    parameter int                 STAGES  = 2,
    parameter logic [WIDTH-1:0]   RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage[i] <= RST_VAL;
                else     stage[i] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage[i] <= RST_VAL;
                else     stage[i] <= stage[i-1];
            end
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/hbs_decode.sv
`timescale 1ns/1ps
module hbs_decode
    import hbs_pkg::*;
#(
    parameter int NUM_AXES = 3,
    parameter int OFFS_W   = 5,
    localparam int ADDR_W  = OFFS_W + AXIS_W
) (
    input  logic [ADDR_W-1:0] addr,
    output axis_sel_t         sel,
    output logic [OFFS_W-1:0] offs
);
    always_comb begin
        sel.axis = addr[ADDR_W-1 -: AXIS_W];
        sel.hit  = axis_in_range(sel.axis, NUM_AXES);
        offs     = addr[OFFS_W-1:0];
    end
endmodule

// File: rtl/hbs_ack_timer.sv
`timescale 1ns/1ps
module hbs_ack_timer #(
    parameter int DELAY   = 2,
    localparam int CNT_W  = $clog2(DELAY + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_act,
    output logic ack_q
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !strobe_act) begin
            cnt   <= '0;
            ack_q <= 1'b0;
        end else if (cnt < CNT_W'(DELAY - 1)) begin
            cnt   <= cnt + CNT_W'(1);
        end else begin
            ack_q <= 1'b1;
        end
    end
endmodule

// File: rtl/hbs_host_slave.sv
`timescale 1ns/1ps
module hbs_host_slave
    import hbs_pkg::*;
#(
    parameter int NUM_AXES    = 3,
    parameter int OFFS_W      = 5,
    parameter int SYNC_STAGES = 2,
    parameter int ACK_DELAY   = 2,
    localparam int ADDR_W     = OFFS_W + AXIS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_sel,
    input  logic              cs_n,
    input  logic              rnw,
    input  logic              ds_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] hd_in,
    output logic [DATA_W-1:0] hd_out,
    output logic              hd_oe,
    output logic              ack_n,
    output logic              rf_rd_en,
    output logic              rf_wr_en,
    output logic [AXIS_W-1:0] rf_axis,
    output logic [OFFS_W-1:0] rf_offs,
    output logic [DATA_W-1:0] rf_wdata,
    input  logic [DATA_W-1:0] rf_rdata
);
    bus_mode_e mode;
    pins_t     pins_raw, pins_s;
    logic      cs_s;

    assign mode     = bus_mode_e'(mode_sel);
    assign pins_raw = '{cs_n: cs_n, ds_n: ds_n, rd_n: rd_n, wr_n: wr_n, rnw: rnw};

    hbs_sync #(
        .WIDTH  ($bits(pins_t)),
        .STAGES (SYNC_STAGES),
        .RST_VAL(PINS_IDLE)
    ) u_sync (
        .clk(clk), .rst(rst), .d(pins_raw), .q(pins_s)
    );

    assign cs_s = pins_s.cs_n;

    // Qualified strobe levels, one per handshake path
    logic act_ack, act_rd, act_wr;
    logic act_ack_d, act_rd_d, act_wr_d;

    assign act_ack = (mode == BUS_ACK)   && !pins_s.cs_n && !pins_s.ds_n;
    assign act_rd  = (mode == BUS_SPLIT) && !pins_s.cs_n && !pins_s.rd_n;
    assign act_wr  = (mode == BUS_SPLIT) && !pins_s.cs_n && !pins_s.wr_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_ack_d <= 1'b0;
            act_rd_d  <= 1'b0;
            act_wr_d  <= 1'b0;
        end else begin
            act_ack_d <= act_ack;
            act_rd_d  <= act_rd;
            act_wr_d  <= act_wr;
        end
    end

    logic ack_start, rd_go, wr_go_now, wr_go_held;
    assign ack_start  = act_ack && !act_ack_d;
    assign rd_go      = (ack_start && pins_s.rnw) || (act_rd && !act_rd_d);
    assign wr_go_now  = ack_start && !pins_s.rnw;
    assign wr_go_held = act_wr_d && !act_wr;

    // Address decode of the live bus
    axis_sel_t         sel_now;
    logic [OFFS_W-1:0] offs_now;

    hbs_decode #(.NUM_AXES(NUM_AXES), .OFFS_W(OFFS_W)) u_dec (
        .addr(addr), .sel(sel_now), .offs(offs_now)
    );

    // Split-mode write holding register: tracks the bus while the strobe is low
    axis_sel_t         hold_sel;
    logic [OFFS_W-1:0] hold_offs;
    logic [DATA_W-1:0] hold_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_sel  <= '0;
            hold_offs <= '0;
            hold_data <= '0;
        end else if (act_wr) begin
            hold_sel  <= sel_now;
            hold_offs <= offs_now;
            hold_data <= hd_in;
        end
    end

    // Request register toward the register file
    logic rd_pend_q, rd_hit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rf_rd_en  <= 1'b0;
            rf_wr_en  <= 1'b0;
            rf_axis   <= '0;
            rf_offs   <= '0;
            rf_wdata  <= '0;
            rd_pend_q <= 1'b0;
            rd_hit_q  <= 1'b0;
        end else begin
            rf_rd_en  <= rd_go && sel_now.hit;
            rf_wr_en  <= (wr_go_now && sel_now.hit) || (wr_go_held && hold_sel.hit);
            rd_pend_q <= rd_go;
            if (rd_go) rd_hit_q <= sel_now.hit;
            if (rd_go || wr_go_now) begin
                rf_axis  <= sel_now.axis;
                rf_offs  <= offs_now;
                rf_wdata <= hd_in;
            end else if (wr_go_held) begin
                rf_axis  <= hold_sel.axis;
                rf_offs  <= hold_offs;
                rf_wdata <= hold_data;
            end
        end
    end

    // Read data capture: out-of-window reads return zero
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (rst)            rdata_q <= '0;
        else if (rd_pend_q) rdata_q <= rd_hit_q ? rf_rdata : '0;
    end

    // Acknowledge timing
    logic ack_q;

    hbs_ack_timer #(.DELAY(ACK_DELAY)) u_ack (
        .clk(clk), .rst(rst), .strobe_act(act_ack), .ack_q(ack_q)
    );

    assign ack_n  = !(ack_q && act_ack);
    assign hd_out = rdata_q;
    assign hd_oe  = (act_ack && pins_s.rnw) || act_rd;

endmodule

// File: rtl/hbs_host_slave_chk.sv
`timescale 1ns/1ps
module hbs_host_slave_chk #(
    parameter int NUM_AXES = 3
) (
    input logic       clk,
    input logic       rst,
    input logic       mode_sel,
    input logic       ack_n,
    input logic       hd_oe,
    input logic       rf_rd_en,
    input logic       rf_wr_en,
    input logic [1:0] rf_axis,
    input logic       act_ack,
    input logic       cs_s
);
    // R3: acknowledge only after the strobe was seen low for two clocks
    a_r3_ack_two_clocks: assert property (@(posedge clk) disable iff (rst)
        $fell(ack_n) |-> ($past(act_ack) && $past(act_ack, 2)));

    // R11: single-cycle requests, never read and write together
    a_r11_rd_single: assert property (@(posedge clk) disable iff (rst)
        rf_rd_en |=> !rf_rd_en);
    a_r11_wr_single: assert property (@(posedge clk) disable iff (rst)
        rf_wr_en |=> !rf_wr_en);
    a_r11_never_both: assert property (@(posedge clk) disable iff (rst)
        !(rf_rd_en && rf_wr_en));

    // R9: requests only inside the configured axis windows
    a_r9_rd_in_window: assert property (@(posedge clk) disable iff (rst)
        rf_rd_en |-> (int'(rf_axis) < NUM_AXES));
    a_r9_wr_in_window: assert property (@(posedge clk) disable iff (rst)
        rf_wr_en |-> (int'(rf_axis) < NUM_AXES));

    // R8: the bus is driven only while the synchronised select is active
    a_r8_oe_needs_cs: assert property (@(posedge clk) disable iff (rst)
        hd_oe |-> !cs_s);

    // R7: no acknowledge while the split-strobe strap is steady
    a_r7_split_silent: assert property (@(posedge clk) disable iff (rst)
        (mode_sel && $past(mode_sel)) |-> ack_n);
endmodule

bind hbs_host_slave hbs_host_slave_chk #(.NUM_AXES(NUM_AXES)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .mode_sel(mode_sel),
    .ack_n   (ack_n),
    .hd_oe   (hd_oe),
    .rf_rd_en(rf_rd_en),
    .rf_wr_en(rf_wr_en),
    .rf_axis (rf_axis),
    .act_ack (act_ack),
    .cs_s    (cs_s)
);

// File: tb/hbs_host_slave_test.sv
`timescale 1ns/1ps
module hbs_host_slave_test;
    localparam int NAX = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_sel = 1'b0;
    logic        cs_n = 1'b1, rnw = 1'b1, ds_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [6:0]  addr = '0;
    logic [15:0] hd_in = '0;
    logic [15:0] hd_out, rf_wdata, rf_rdata;
    logic        hd_oe, ack_n, rf_rd_en, rf_wr_en;
    logic [1:0]  rf_axis;
    logic [4:0]  rf_offs;

    int n_chk = 0;
    int n_bad = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    bit done = 1'b0;

    logic [15:0] mem [4][32];

    always #10 clk = ~clk;

    hbs_host_slave uut (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .cs_n(cs_n), .rnw(rnw),
        .ds_n(ds_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr), .hd_in(hd_in),
        .hd_out(hd_out), .hd_oe(hd_oe), .ack_n(ack_n), .rf_rd_en(rf_rd_en),
        .rf_wr_en(rf_wr_en), .rf_axis(rf_axis), .rf_offs(rf_offs),
        .rf_wdata(rf_wdata), .rf_rdata(rf_rdata)
    );

    // Register file model
    assign rf_rdata = mem[rf_axis][rf_offs];

    always @(posedge clk) begin
        if (rst) begin
            for (int a = 0; a < 4; a++)
                for (int o = 0; o < 32; o++)
                    mem[a][o] <= 16'(16'h1000 * (a + 1) + o * 3 + 1);
        end else begin
            if (rf_wr_en) begin
                mem[rf_axis][rf_offs] <= rf_wdata;
                wr_cnt <= wr_cnt + 1;
            end
            if (rf_rd_en) rd_cnt <= rd_cnt + 1;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic t_reset();
        chk("R1 ack_n", 32'(ack_n), 1);
        chk("R1 hd_oe", 32'(hd_oe), 0);
        chk("R1 rf_rd_en", 32'(rf_rd_en), 0);
        chk("R1 rf_wr_en", 32'(rf_wr_en), 0);
    endtask

    task automatic t_ack_read(input int ax, input int of);
        int r0 = rd_cnt;
        bit hit = (ax < NAX);
        logic [15:0] exp = hit ? mem[ax][of] : 16'h0;
        mode_sel = 1'b0; cs_n = 1'b0; rnw = 1'b1; addr = {2'(ax), 5'(of)};
        tick(1);
        ds_n = 1'b0;
        tick(3);
        chk("R3 ack_n before due edge", 32'(ack_n), 1);
        chk("R2/R9 rf_rd_en on third edge", 32'(rf_rd_en), 32'(hit));
        if (hit) begin
            chk("R10 rf_axis", 32'(rf_axis), 32'(ax));
            chk("R10 rf_offs", 32'(rf_offs), 32'(of));
        end
        tick(1);
        chk("R3 ack_n low on fourth edge", 32'(ack_n), 0);
        chk("R2/R9 hd_out", 32'(hd_out), 32'(exp));
        chk("R2 hd_oe", 32'(hd_oe), 1);
        tick(6);
        chk("R11 one read per strobe", 32'(rd_cnt - r0), 32'(hit));
        ds_n = 1'b1;
        tick(1);
        chk("R3 ack_n held one edge after release", 32'(ack_n), 0);
        tick(1);
        chk("R3 ack_n released", 32'(ack_n), 1);
        chk("R2 hd_oe released", 32'(hd_oe), 0);
        cs_n = 1'b1;
        tick(2);
    endtask

    task automatic t_ack_write(input int ax, input int of, input logic [15:0] d);
        int w0 = wr_cnt;
        bit hit = (ax < NAX);
        mode_sel = 1'b0; cs_n = 1'b0; rnw = 1'b0; addr = {2'(ax), 5'(of)}; hd_in = d;
        tick(1);
        ds_n = 1'b0;
        tick(2);
        chk("R4 no write before third edge", 32'(rf_wr_en), 0);
        tick(1);
        chk("R4/R9 rf_wr_en on third edge", 32'(rf_wr_en), 32'(hit));
        if (hit) begin
            chk("R4 rf_wdata", 32'(rf_wdata), 32'(d));
            chk("R10 rf_axis write", 32'(rf_axis), 32'(ax));
            chk("R10 rf_offs write", 32'(rf_offs), 32'(of));
        end
        chk("R4 hd_oe stays low", 32'(hd_oe), 0);
        tick(1);
        chk("R3 ack_n on write", 32'(ack_n), 0);
        tick(5);
        chk("R11/R9 one write per strobe", 32'(wr_cnt - w0), 32'(hit));
        chk("R4 hd_oe low in write", 32'(hd_oe), 0);
        ds_n = 1'b1;
        tick(2);
        cs_n = 1'b1; rnw = 1'b1;
        tick(2);
    endtask

    task automatic t_split_read(input int ax, input int of);
        bit hit = (ax < NAX);
        logic [15:0] exp = hit ? mem[ax][of] : 16'h0;
        mode_sel = 1'b1; cs_n = 1'b0; addr = {2'(ax), 5'(of)};
        tick(1);
        rd_n = 1'b0;
        tick(3);
        chk("R5/R9 split rf_rd_en", 32'(rf_rd_en), 32'(hit));
        chk("R7 ack_n idle in split", 32'(ack_n), 1);
        tick(1);
        chk("R5 split hd_out", 32'(hd_out), 32'(exp));
        chk("R5 split hd_oe", 32'(hd_oe), 1);
        chk("R7 ack_n stays idle", 32'(ack_n), 1);
        rd_n = 1'b1;
        tick(2);
        chk("R5 split hd_oe released", 32'(hd_oe), 0);
        cs_n = 1'b1;
        tick(2);
    endtask

    task automatic t_split_write(input int ax, input int of, input logic [15:0] d);
        int w0 = wr_cnt;
        bit hit = (ax < NAX);
        mode_sel = 1'b1; cs_n = 1'b0; addr = {2'(ax), 5'(of)}; hd_in = d;
        tick(1);
        wr_n = 1'b0;
        tick(8);
        chk("R6 no write while strobe low", 32'(wr_cnt - w0), 0);
        chk("R7 ack_n idle during write", 32'(ack_n), 1);
        wr_n = 1'b1;
        tick(2);
        chk("R6 no write before third edge", 32'(rf_wr_en), 0);
        tick(1);
        chk("R6/R9 write after rising strobe", 32'(rf_wr_en), 32'(hit));
        if (hit) chk("R6 split rf_wdata", 32'(rf_wdata), 32'(d));
        hd_in = ~d; addr = 7'h7F;
        tick(3);
        chk("R11 one split write", 32'(wr_cnt - w0), 32'(hit));
        cs_n = 1'b1;
        tick(2);
    endtask

    task automatic t_cs_idle();
        int r0 = rd_cnt;
        int w0 = wr_cnt;
        mode_sel = 1'b0; cs_n = 1'b1; rnw = 1'b1; addr = 7'h03;
        ds_n = 1'b0;
        tick(6);
        chk("R8 ack_n with cs high", 32'(ack_n), 1);
        chk("R8 hd_oe with cs high", 32'(hd_oe), 0);
        ds_n = 1'b1; rnw = 1'b0;
        tick(1);
        ds_n = 1'b0;
        tick(6);
        ds_n = 1'b1; rnw = 1'b1;
        mode_sel = 1'b1; rd_n = 1'b0;
        tick(6);
        chk("R8 split hd_oe with cs high", 32'(hd_oe), 0);
        rd_n = 1'b1; wr_n = 1'b0;
        tick(4);
        wr_n = 1'b1;
        tick(6);
        chk("R8 no reads with cs high", 32'(rd_cnt - r0), 0);
        chk("R8 no writes with cs high", 32'(wr_cnt - w0), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst = 1'b0;
        tick(1);
        t_reset();
        t_ack_read(0, 0);
        t_ack_read(2, 31);
        t_ack_write(1, 5, 16'hBEEF);
        t_ack_read(1, 5);
        t_split_read(2, 9);
        t_split_write(0, 17, 16'h5A3C);
        t_ack_read(0, 17);
        t_split_read(0, 17);
        t_ack_read(3, 2);
        t_ack_write(3, 2, 16'h1234);
        t_split_read(3, 7);
        t_split_write(3, 7, 16'hCAFE);
        t_cs_idle();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule